// File: doc/BRIEF.md
# Segment Selector Load with Descriptor Cache

This block holds one segment register together with a hidden copy of the descriptor that the register's selector points to. A 16-bit selector is written into it. If the value differs from the selector already held, the block splits the value into a 13-bit table index, a table-indicator bit and a two-bit requested privilege level. It then picks the base and limit of either the global table or the local table, both supplied as inputs, and checks that the whole 8-byte entry lies inside that table. If it does, the block fetches the entry as two 32-bit words over a simple request/ready memory port.

After both words arrive, the block rebuilds the scattered base and limit fields and widens the limit when the granularity bit is set. It tests the present and segment-kind bits, and then either updates the cache and pulses `done`, or leaves everything as it was and pulses `fault` with a vector number and the faulting selector. Writing the selector value already held starts no table access. A null selector (index 0 in the global table) is accepted without any memory traffic and marks the cache invalid. Any later use of the register while the cache is invalid raises `use_fault`.

Top module: `seg_desc_cache`

## Requirements
- R1: Selector bits 15:3 are the index, bit 2 selects the table (0 = global, 1 = local) and bits 1:0 are the requested privilege level. The low word is read at table_base + index*8, then the high word at that address + 4.
- R2: A write of a selector equal to the one held (`sel_q`) issues no memory request and produces neither `done` nor `fault`.
- R3: If index*8+7 is greater than the chosen table limit, no memory request is made and `fault` pulses with `fault_vec` = 13 and `fault_sel` = the written selector.
- R4: A selector with index 0 and table bit 0 completes with `done` and no memory request. It sets `sel_q` to the written value and clears `cache_valid`.
- R5: On success, `cache_base` = {hi[31:24], hi[7:0], lo[31:16]} and the 20-bit limit is {hi[19:16], lo[15:0]}. `cache_limit` is that limit when hi[23] = 0, or limit*4096 + 4095 when hi[23] = 1. `cache_access` = hi[15:8], `cache_flags` = hi[23:20], `cache_valid` = 1 and `sel_q` = the selector.
- R6: A fetched entry with hi[15] (present) = 0 faults with vector 11. An entry with hi[12] = 0 (a system entry) faults with vector 13. On any fault, `sel_q` and the whole cache stay unchanged.
- R7: While a read waits for `mem_ready`, `mem_req` and `mem_addr` hold steady. `mem_req` is low whenever the block is idle.
- R8: `use_fault` is high in the same cycle that `use_req` is high while `cache_valid` is 0, and low otherwise.
- R9: A selector write that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `fault`, `mem_req` and `cache_valid` are 0 and `sel_q` is 0.
- R11: `done` and `fault` are single-cycle pulses that are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_in | input | 16 | Selector value to load |
| gtab_base | input | AW | Global table base address |
| gtab_limit | input | TLW | Global table last byte offset |
| ltab_base | input | AW | Local table base address |
| ltab_limit | input | TLW | Local table last byte offset |
| use_req | input | 1 | A memory use through this register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ready | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Load completed pulse |
| fault | output | 1 | Load rejected pulse |
| fault_vec | output | 8 | Fault vector number (11 or 13) |
| fault_sel | output | 16 | Selector that caused the fault |
| sel_q | output | 16 | Selector currently held |
| cache_valid | output | 1 | Cached entry is usable |
| cache_base | output | 32 | Cached segment base |
| cache_limit | output | 32 | Cached byte limit after granularity |
| cache_access | output | 8 | Cached access-rights byte |
| cache_flags | output | 4 | Cached G, D, reserved, AVL bits |
| use_fault | output | 1 | Use of an invalid register |

## Verification
A wrong state register shows up at the ports within one load. It appears as a missing or extra request, an address that is off by the table base or by 4, or a `done`/`fault` pulse that arrives early, arrives late or repeats. A field that is unpacked from the wrong place shows up in the cache outputs in the same cycle as `done`. A cache that a fault corrupts shows up on the next read of the outputs, because they are compared against the last successful load. A stale held selector shows up on the next write: that write either fetches when it should not, or stays silent when it should fetch.

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
  parameter int AW  = 32,
  parameter int TLW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_wr,
  input  logic [15:0]    sel_in,
  input  logic [AW-1:0]  gtab_base,
  input  logic [TLW-1:0] gtab_limit,
  input  logic [AW-1:0]  ltab_base,
  input  logic [TLW-1:0] ltab_limit,
  input  logic           use_req,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ready,
  input  logic [31:0]    mem_rdata,
  output logic           busy,
  output logic           done,
  output logic           fault,
  output logic [7:0]     fault_vec,
  output logic [15:0]    fault_sel,
  output logic [15:0]    sel_q,
  output logic           cache_valid,
  output logic [31:0]    cache_base,
  output logic [31:0]    cache_limit,
  output logic [7:0]     cache_access,
  output logic [3:0]     cache_flags,
  output logic           use_fault
);
  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_NP = 8'd11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_CHECK, ST_DONE, ST_FAULT
  } st_t;

  st_t         state;
  logic [15:0] pend_sel;
  logic [31:0] lo_w, hi_w;

  wire [12:0]   idx      = sel_in[15:3];
  wire          tsel     = sel_in[2];
  wire [AW-1:0] tab_base = tsel ? ltab_base : gtab_base;
  wire [31:0]   tab_lim  = tsel ? 32'(ltab_limit) : 32'(gtab_limit);
  wire [31:0]   last_b   = {16'h0, idx, 3'b111};
  wire          oob      = last_b > tab_lim;
  wire          is_null  = (idx == 13'd0) && !tsel;
  wire          accept   = (state == ST_IDLE) && sel_wr && (sel_in != sel_q);

  wire [19:0]   lim20    = {hi_w[19:16], lo_w[15:0]};
  wire          gran     = hi_w[23];

  assign mem_req   = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign busy      = state != ST_IDLE;
  assign done      = state == ST_DONE;
  assign fault     = state == ST_FAULT;
  assign use_fault = use_req && !cache_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      pend_sel     <= '0;
      lo_w         <= '0;
      hi_w         <= '0;
      mem_addr     <= '0;
      fault_vec    <= '0;
      fault_sel    <= '0;
      sel_q        <= '0;
      cache_valid  <= 1'b0;
      cache_base   <= '0;
      cache_limit  <= '0;
      cache_access <= '0;
      cache_flags  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          pend_sel <= sel_in;
          if (is_null) begin
            sel_q       <= sel_in;
            cache_valid <= 1'b0;
            state       <= ST_DONE;
          end else if (oob) begin
            fault_vec <= VEC_GP;
            fault_sel <= sel_in;
            state     <= ST_FAULT;
          end else begin
            mem_addr <= tab_base + AW'({idx, 3'b000});
            state    <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_ready) begin
          lo_w     <= mem_rdata;
          mem_addr <= mem_addr + AW'(4);
          state    <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_ready) begin
          hi_w  <= mem_rdata;
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!hi_w[15] || !hi_w[12]) begin
            fault_vec <= hi_w[15] ? VEC_GP : VEC_NP;
            fault_sel <= pend_sel;
            state     <= ST_FAULT;
          end else begin
            sel_q        <= pend_sel;
            cache_valid  <= 1'b1;
            cache_base   <= {hi_w[31:24], hi_w[7:0], lo_w[31:16]};
            cache_limit  <= gran ? {lim20, 12'hFFF} : {12'h000, lim20};
            cache_access <= hi_w[15:8];
            cache_flags  <= hi_w[23:20];
            state        <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_desc_cache_chk.sv
module seg_desc_cache_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [7:0]    fault_vec,
  input logic [15:0]   sel_q,
  input logic          cache_valid,
  input logic [31:0]   cache_base,
  input logic [31:0]   cache_limit
);
  assert_done_fault_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_idle_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_fault_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_vec == 8'd11 || fault_vec == 8'd13));

  assert_fault_keeps_cache_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(sel_q) && $stable(cache_valid) && $stable(cache_base) && $stable(cache_limit)));

  assert_null_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sel_q[15:2] == 14'd0) |-> !cache_valid);
endmodule

bind seg_desc_cache seg_desc_cache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .busy(busy), .done(done), .fault(fault),
  .fault_vec(fault_vec), .sel_q(sel_q), .cache_valid(cache_valid),
  .cache_base(cache_base), .cache_limit(cache_limit)
);

// File: tb/test_seg_desc_cache.sv
`timescale 1ns/1ps
module test_seg_desc_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0;
  logic [15:0] sel_in = '0;
  logic [31:0] gtab_base = 32'h0000_1000;
  logic [15:0] gtab_limit = 16'h003F;
  logic [31:0] ltab_base = 32'h0000_2000;
  logic [15:0] ltab_limit = 16'h001F;
  logic        use_req = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, fault, cache_valid, use_fault;
  logic [7:0]  fault_vec, cache_access;
  logic [15:0] fault_sel, sel_q;
  logic [31:0] cache_base, cache_limit;
  logic [3:0]  cache_flags;

  int tests = 0, fails = 0;
  int lat = 0, wcnt = 0, reads = 0;
  logic [31:0] ra0, ra1;
  logic [15:0] e_sel = '0;
  logic        e_valid = 1'b0;
  logic [31:0] e_base = '0, e_limit = '0;
  logic [7:0]  e_acc = '0;
  logic [3:0]  e_flags = '0;

  always #2.5 clk = ~clk;

  seg_desc_cache i_seg_desc_cache (.*);

  function automatic logic [63:0] desc_of(input logic ti, input int i);
    logic [31:0] b; logic [19:0] l; logic [7:0] a; logic [3:0] f;
    if (!ti) begin
      b = 32'h0010_0000 * 32'(i) + 32'h123 * 32'(i);
      l = 20'(32'h1111 * 32'(i));
      a = (i == 5) ? 8'h12 : (i == 6) ? 8'h82 : 8'h92;
      f = {i[0], 3'b100};
    end else begin
      b = 32'hA000_0000 + 32'h10 * 32'(i);
      l = 20'hFFFFF - 20'(i);
      a = 8'hF2;
      f = 4'b0100;
    end
    return {b[31:24], f, l[19:16], a, b[23:16], b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [63:0] d;
    if (a >= 32'h1000 && a < 32'h1100) d = desc_of(1'b0, int'((a - 32'h1000) >> 3));
    else if (a >= 32'h2000 && a < 32'h2100) d = desc_of(1'b1, int'((a - 32'h2000) >> 3));
    else d = 64'hDEAD_BEEF_DEAD_BEEF;
    return a[2] ? d[63:32] : d[31:0];
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= word_at(mem_addr);
        if (reads == 0) ra0 = mem_addr; else ra1 = mem_addr;
        reads = reads + 1;
        wcnt = 0;
      end else begin
        mem_ready <= 1'b0;
        wcnt = wcnt + 1;
      end
    end else begin
      mem_ready <= 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_end(output logic got_done, output logic got_fault);
    int n = 0;
    #1;
    while (!(done || fault) && n < 100) begin @(negedge clk); #1; n++; end
    got_done = done; got_fault = fault;
    chk(n < 100, "R11 load never ended", 32'(n), 32'd100);
  endtask

  task automatic do_load(input logic [15:0] s, input int lt);
    logic gd, gf, ti, is_null, oob;
    int idx;
    logic [63:0] d;
    logic [31:0] lim, exp_addr;
    logic [19:0] l20;
    lat = lt; reads = 0;
    @(negedge clk); sel_wr = 1'b1; sel_in = s;
    @(negedge clk); sel_wr = 1'b0;
    wait_end(gd, gf);
    ti = s[2]; idx = int'(s[15:3]);
    lim = ti ? 32'h1F : 32'h3F;
    is_null = (idx == 0) && !ti;
    oob = (32'(idx) * 8 + 7) > lim;
    d = desc_of(ti, idx);
    if (is_null) begin
      chk(gd && !gf, "R4 null done", {30'b0, gd, gf}, 32'h2);
      chk(reads == 0, "R4 null reads", 32'(reads), 0);
      e_sel = s; e_valid = 1'b0;
      chk(!cache_valid && sel_q == s, "R4 null cache", {15'b0, cache_valid, sel_q}, {16'b0, s});
    end else if (oob) begin
      chk(gf && fault_vec == 8'd13 && fault_sel == s, "R3 bounds fault", {gf, 7'b0, fault_vec, fault_sel}, {9'h100, 7'd13, s});
      chk(reads == 0, "R3 bounds reads", 32'(reads), 0);
    end else begin
      exp_addr = (ti ? 32'h2000 : 32'h1000) + 32'(idx) * 8;
      chk(reads == 2 && ra0 == exp_addr && ra1 == exp_addr + 4, "R1 addresses", ra0, exp_addr);
      if (!d[47]) begin
        chk(gf && fault_vec == 8'd11 && fault_sel == s, "R6 not present", {gf, 7'b0, fault_vec, fault_sel}, {9'h100, 7'd11, s});
      end else if (!d[44]) begin
        chk(gf && fault_vec == 8'd13 && fault_sel == s, "R6 system entry", {gf, 7'b0, fault_vec, fault_sel}, {9'h100, 7'd13, s});
      end else begin
        l20 = {d[51:48], d[15:0]};
        e_sel = s; e_valid = 1'b1;
        e_base = {d[63:56], d[39:32], d[31:16]};
        e_limit = d[55] ? {l20, 12'hFFF} : {12'h0, l20};
        e_acc = d[47:40]; e_flags = d[55:52];
        chk(gd && !gf, "R5 done", {30'b0, gd, gf}, 32'h2);
      end
    end
    chk(sel_q == e_sel && cache_valid == e_valid, "R5/R6 selector held", {15'b0, cache_valid, sel_q}, {15'b0, e_valid, e_sel});
    if (e_valid)
      chk(cache_base == e_base && cache_limit == e_limit && cache_access == e_acc && cache_flags == e_flags,
          "R5/R6 cache fields", cache_base ^ cache_limit, e_base ^ e_limit);
    @(negedge clk); #1;
    chk(!done && !fault, "R11 pulse width", {30'b0, done, fault}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic gd, gf;
    logic [15:0] a_sel, b_sel;
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !fault && !mem_req && !cache_valid && sel_q == 16'h0, "R10 reset",
        {27'b0, busy, done, fault, mem_req, cache_valid}, 0);
    rst_n = 1'b1;

    for (int ti = 0; ti < 2; ti++)
      for (int idx = 0; idx < 10; idx++)
        do_load({13'(idx), 1'(ti), 2'((idx + 1) % 4)}, (idx + ti) % 3);

    do_load({13'd3, 1'b0, 2'd2}, 1);
    reads = 0;
    @(negedge clk); sel_wr = 1'b1; sel_in = {13'd3, 1'b0, 2'd2};
    @(negedge clk); sel_wr = 1'b0;
    n = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); #1; if (done || fault || busy) n++; end
    chk(n == 0 && reads == 0, "R2 same selector", 32'(reads + n), 0);

    use_req = 1'b1; #1;
    chk(!use_fault, "R8 valid use", {31'b0, use_fault}, 0);
    use_req = 1'b0;

    a_sel = {13'd7, 1'b0, 2'd0};
    b_sel = {13'd1, 1'b1, 2'd3};
    lat = 2; reads = 0;
    @(negedge clk); sel_wr = 1'b1; sel_in = a_sel;
    @(negedge clk); sel_in = b_sel;
    @(negedge clk); sel_wr = 1'b0;
    wait_end(gd, gf);
    chk(gd && sel_q == a_sel && reads == 2, "R9 write while busy", {16'(reads), sel_q}, {16'd2, a_sel});
    repeat (10) @(negedge clk);
    #1;
    chk(!busy && reads == 2, "R9 no second load", 32'(reads), 2);
    e_sel = a_sel; e_valid = 1'b1;

    do_load({13'd0, 1'b0, 2'd3}, 0);
    @(negedge clk); use_req = 1'b1; #1;
    chk(use_fault, "R8 invalid use", {31'b0, use_fault}, 1);
    use_req = 1'b0; #1;
    chk(!use_fault, "R8 no use", {31'b0, use_fault}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule